// File: doc/BRIEF.md
# Core Module Control Registers

This block is the system control register file of a processor core module. It sits on a simple word-addressed 32-bit register bus. Software reads identification and status constants through it. It can also reprogram two oscillator settings, but only after writing a 16-bit unlock key. Other fields select whether RAM or boot flash answers at address zero, drive a front-panel LED and request a system reset. It also provides volatile and non-volatile flag words with separate set and clear addresses, a free-running counter paced by a 24 MHz reference strobe, and a small set of interrupt enable and soft-interrupt registers.

Every bus access is one cycle wide. A read returns its data one clock later, marked by a one-cycle valid pulse. Writes take effect at the clock edge that samples them. An access to an offset with no meaning (including a read of a write-only address or a write to a read-only one) raises a one-cycle error flag. An unimplemented read returns zero, and an unimplemented write is discarded. The remap select and the LED drive come straight from register bits. The reset request is a single-cycle pulse.

Top module: `cm_sysctl`

## Requirements
- R1: Word offset 0 reads 0x411A3001, offset 1 reads 0 and offset 4 reads 0x00100000; writes to these offsets are discarded and flagged as errors.
- R2: A read (bus_sel high, bus_wr low) returns its data on bus_rdata with bus_rvalid high for exactly the following cycle, for every read including erroneous ones.
- R3: A write to offset 5 keeps only bits 15:0; reading offset 5 returns 0x0001A05F when the stored key is 0xA05F and the stored 16-bit value otherwise.
- R4: Writes to offset 2 (main oscillator) and offset 7 (auxiliary oscillator) update the register only while offset 5 holds 0xA05F and are ignored otherwise.
- R5: Offset 3 stores only bit 0 and bit 2; led_on follows bit 0 and remap_ram follows bit 2 (1 = RAM at address zero, 0 = boot flash); all other bits read zero and both outputs are 0 after reset.
- R6: A write to offset 3 with bit 3 set gives sys_reset_req high for exactly the cycle after the write; bit 3 always reads back zero.
- R7: Writing offset 12 ORs the data into the volatile flags and writing offset 13 clears the bits written as 1; offsets 14 and 15 do the same for the non-volatile flags; offsets 12 and 14 read the current values and each bank leaves the other untouched.
- R8: After reset, offset 2 reads 0x01000048, offset 7 reads 0x0007FEFF, offset 9 reads 0x00000112 and offset 8 reads 0x00011122 ORed with the size code (0x10 for 256 MB or more, 0x0C for 128 MB, 0x08 for 64 MB, 0x04 for 32 MB, else 0); offsets 8 and 9 are plain read/write words.
- R9: Offset 10 reads a counter that is cleared by reset, advances by one on each cycle where ref_tick is high and wraps freely; a read in a tick cycle returns the count before that tick, and a write to offset 10 is discarded and flagged.
- R10: Offsets 18/19 set/clear IRQ enable bits and 26/27 set/clear FIQ enable bits; writing bit 0 to offset 20/21 sets/clears the soft interrupt (raw level bit 0); offsets 17 and 25 read the raw level, 16 and 24 read level AND the respective enable, 18 and 26 read the enables, 20 reads level bit 0.
- R11: Offsets 32 to 35 read zero, ignore writes and never raise bus_err.
- R12: Any other offset, any read of 13, 15, 19, 21, 27, and any write to 0, 1, 4, 10, 16, 17, 24, 25 returns zero or is discarded, and bus_err is high for exactly the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_err | output | 1 | One-cycle error pulse for an unimplemented access |
| ref_tick | input | 1 | 24 MHz reference strobe, one cycle wide |
| remap_ram | output | 1 | 1 = RAM mapped at address zero |
| led_on | output | 1 | LED drive |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
Two functions can land in the same cycle: a reference tick and a read of the counter. The bench raises ref_tick in the same cycle as the counter read. The returned value must equal the count before that tick, and the next read must show it one higher. A second collision is a control write that stores the LED and remap bits while also carrying the reset bit. Here the outputs must take the stored bits in the same cycle as the reset pulse, and the read-back must still show bit 3 as zero.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;

  localparam logic [7:0] OFS_ID       = 8'd0;
  localparam logic [7:0] OFS_PROC     = 8'd1;
  localparam logic [7:0] OFS_OSC      = 8'd2;
  localparam logic [7:0] OFS_CTRL     = 8'd3;
  localparam logic [7:0] OFS_STAT     = 8'd4;
  localparam logic [7:0] OFS_LOCK     = 8'd5;
  localparam logic [7:0] OFS_AUX      = 8'd7;
  localparam logic [7:0] OFS_SDRAM    = 8'd8;
  localparam logic [7:0] OFS_INIT     = 8'd9;
  localparam logic [7:0] OFS_REFCNT   = 8'd10;
  localparam logic [7:0] OFS_FLAG_SET = 8'd12;
  localparam logic [7:0] OFS_IRQ_STAT = 8'd16;
  localparam logic [7:0] OFS_IRQ_RAW  = 8'd17;
  localparam logic [7:0] OFS_IRQ_ENS  = 8'd18;
  localparam logic [7:0] OFS_IRQ_ENC  = 8'd19;
  localparam logic [7:0] OFS_SOFT_SET = 8'd20;
  localparam logic [7:0] OFS_SOFT_CLR = 8'd21;
  localparam logic [7:0] OFS_FIQ_STAT = 8'd24;
  localparam logic [7:0] OFS_FIQ_RAW  = 8'd25;
  localparam logic [7:0] OFS_FIQ_ENS  = 8'd26;
  localparam logic [7:0] OFS_FIQ_ENC  = 8'd27;
  localparam logic [7:0] OFS_VOLT_LO  = 8'd32;
  localparam logic [7:0] OFS_VOLT_HI  = 8'd35;

  localparam logic [31:0] ID_WORD    = 32'h411A3001;
  localparam logic [31:0] STAT_WORD  = 32'h00100000;
  localparam logic [31:0] OSC_RST    = 32'h01000048;
  localparam logic [31:0] AUX_RST    = 32'h0007FEFF;
  localparam logic [31:0] INIT_RST   = 32'h00000112;
  localparam logic [31:0] SDRAM_BASE = 32'h00011122;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  // Control register bit positions (bit 3 is the reset request strobe)
  localparam int CTRL_LED   = 0;
  localparam int CTRL_REMAP = 2;
  localparam int CTRL_RESET = 3;

  // One set/clear command applied to a register in a given cycle
  typedef struct packed {
    logic        set;
    logic        clr;
    logic [31:0] data;
  } setclr_t;

  function automatic logic [31:0] sdram_size_code(int mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

endpackage

// File: rtl/cm_key_gate.sv
module cm_key_gate
  import cm_sysctl_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_we,
  input  logic             osc_we,
  input  logic             aux_we,
  input  logic [KEY_W-1:0] key_in,
  input  logic [31:0]      wdata,
  output logic [KEY_W-1:0] lock_q,
  output logic             unlocked,
  output logic [31:0]      osc_q,
  output logic [31:0]      aux_q
);

  assign unlocked = (lock_q == KEY_W'(UNLOCK_KEY));

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
      osc_q  <= OSC_RST;
      aux_q  <= AUX_RST;
    end else begin
      if (lock_we)             lock_q <= key_in;
      if (osc_we && unlocked)  osc_q  <= wdata;
      if (aux_we && unlocked)  aux_q  <= wdata;
    end
  end

endmodule

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg
  import cm_sysctl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  setclr_t      cmd,
  output logic [W-1:0] q
);

  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;

  assign set_mask = cmd.set ? cmd.data[W-1:0] : '0;
  assign clr_mask = cmd.clr ? cmd.data[W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_mask) & ~clr_mask;
  end

endmodule

// File: rtl/cm_ref_counter.sv
module cm_ref_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + 1'b1;
  end

endmodule

// File: rtl/cm_irq_regs.sv
module cm_irq_regs
  import cm_sysctl_pkg::*;
#(
  parameter int IRQ_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  setclr_t          irq_cmd,
  input  setclr_t          fiq_cmd,
  input  logic             soft_set,
  input  logic             soft_clr,
  output logic [IRQ_W-1:0] raw_lvl,
  output logic [IRQ_W-1:0] irq_en,
  output logic [IRQ_W-1:0] fiq_en
);

  logic soft_q;

  cm_setclr_reg #(.W(IRQ_W)) u_irq_en (.clk(clk), .rst(rst), .cmd(irq_cmd), .q(irq_en));
  cm_setclr_reg #(.W(IRQ_W)) u_fiq_en (.clk(clk), .rst(rst), .cmd(fiq_cmd), .q(fiq_en));

  always_ff @(posedge clk) begin
    if (rst) soft_q <= 1'b0;
    else     soft_q <= (soft_q | soft_set) & ~soft_clr;
  end

  assign raw_lvl = IRQ_W'(soft_q);

endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
  import cm_sysctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int MEM_MB = 128,
  parameter int CNT_W  = 32,
  parameter int FLAG_W = 32,
  parameter int IRQ_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic              ref_tick,
  output logic              remap_ram,
  output logic              led_on,
  output logic              sys_reset_req
);

  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);
  localparam int          KEY_W     = 16;
  localparam int          NBANK     = 2;

  logic [7:0] ofs;
  logic       wr_en;
  logic       rd_en;

  assign ofs   = 8'(bus_addr);
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  // ---------------- lock-gated oscillator words ----------------
  logic [KEY_W-1:0] lock_q;
  logic             unlocked;
  logic [31:0]      osc_q;
  logic [31:0]      aux_q;

  cm_key_gate #(.KEY_W(KEY_W)) u_key (
    .clk     (clk),
    .rst     (rst),
    .lock_we (wr_en && ofs == OFS_LOCK),
    .osc_we  (wr_en && ofs == OFS_OSC),
    .aux_we  (wr_en && ofs == OFS_AUX),
    .key_in  (bus_wdata[KEY_W-1:0]),
    .wdata   (bus_wdata),
    .lock_q  (lock_q),
    .unlocked(unlocked),
    .osc_q   (osc_q),
    .aux_q   (aux_q)
  );

  // ---------------- flag banks: volatile (0) and non-volatile (1) ----------------
  setclr_t           flag_cmd [NBANK];
  logic [FLAG_W-1:0] flag_q   [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_flag
    localparam logic [7:0] SET_OFS = OFS_FLAG_SET + 8'(2 * g);
    localparam logic [7:0] CLR_OFS = SET_OFS + 8'd1;

    assign flag_cmd[g] = '{set:  wr_en && ofs == SET_OFS,
                           clr:  wr_en && ofs == CLR_OFS,
                           data: bus_wdata};

    cm_setclr_reg #(.W(FLAG_W)) u_bank (
      .clk(clk), .rst(rst), .cmd(flag_cmd[g]), .q(flag_q[g])
    );
  end

  // ---------------- interrupt enables and soft level ----------------
  setclr_t          irq_cmd;
  setclr_t          fiq_cmd;
  logic [IRQ_W-1:0] raw_lvl;
  logic [IRQ_W-1:0] irq_en;
  logic [IRQ_W-1:0] fiq_en;

  assign irq_cmd = '{set: wr_en && ofs == OFS_IRQ_ENS, clr: wr_en && ofs == OFS_IRQ_ENC,
                     data: bus_wdata};
  assign fiq_cmd = '{set: wr_en && ofs == OFS_FIQ_ENS, clr: wr_en && ofs == OFS_FIQ_ENC,
                     data: bus_wdata};

  cm_irq_regs #(.IRQ_W(IRQ_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .irq_cmd (irq_cmd),
    .fiq_cmd (fiq_cmd),
    .soft_set(wr_en && ofs == OFS_SOFT_SET && bus_wdata[0]),
    .soft_clr(wr_en && ofs == OFS_SOFT_CLR && bus_wdata[0]),
    .raw_lvl (raw_lvl),
    .irq_en  (irq_en),
    .fiq_en  (fiq_en)
  );

  // ---------------- reference counter ----------------
  logic [CNT_W-1:0] ref_cnt;

  cm_ref_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(ref_tick), .count(ref_cnt)
  );

  // ---------------- plain words and control ----------------
  logic [31:0] sdram_q;
  logic [31:0] init_q;
  logic        ctrl_wr;

  assign ctrl_wr = wr_en && ofs == OFS_CTRL;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdram_q       <= SDRAM_RST;
      init_q        <= INIT_RST;
      led_on        <= 1'b0;
      remap_ram     <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      if (wr_en && ofs == OFS_SDRAM) sdram_q <= bus_wdata;
      if (wr_en && ofs == OFS_INIT)  init_q  <= bus_wdata;
      if (ctrl_wr) begin
        led_on    <= bus_wdata[CTRL_LED];
        remap_ram <= bus_wdata[CTRL_REMAP];
      end
      sys_reset_req <= ctrl_wr & bus_wdata[CTRL_RESET];
    end
  end

  // ---------------- decode ----------------
  logic [31:0] rd_val;
  logic        rd_ok;
  logic        wr_ok;
  logic        volt_hit;

  assign volt_hit = (ofs >= OFS_VOLT_LO) && (ofs <= OFS_VOLT_HI);

  always_comb begin
    rd_val = '0;
    rd_ok  = 1'b1;
    unique case (ofs)
      OFS_ID:       rd_val = ID_WORD;
      OFS_PROC:     rd_val = '0;
      OFS_OSC:      rd_val = osc_q;
      OFS_CTRL:     begin
                      rd_val[CTRL_LED]   = led_on;
                      rd_val[CTRL_REMAP] = remap_ram;
                    end
      OFS_STAT:     rd_val = STAT_WORD;
      OFS_LOCK:     rd_val = {15'd0, unlocked, 16'(lock_q)};
      OFS_AUX:      rd_val = aux_q;
      OFS_SDRAM:    rd_val = sdram_q;
      OFS_INIT:     rd_val = init_q;
      OFS_REFCNT:   rd_val = 32'(ref_cnt);
      OFS_FLAG_SET: rd_val = 32'(flag_q[0]);
      8'd14:        rd_val = 32'(flag_q[1]);
      OFS_IRQ_STAT: rd_val = 32'(raw_lvl & irq_en);
      OFS_IRQ_RAW:  rd_val = 32'(raw_lvl);
      OFS_IRQ_ENS:  rd_val = 32'(irq_en);
      OFS_SOFT_SET: rd_val = {31'd0, raw_lvl[0]};
      OFS_FIQ_STAT: rd_val = 32'(raw_lvl & fiq_en);
      OFS_FIQ_RAW:  rd_val = 32'(raw_lvl);
      OFS_FIQ_ENS:  rd_val = 32'(fiq_en);
      default:      rd_ok  = volt_hit;
    endcase
  end

  always_comb begin
    unique case (ofs)
      OFS_OSC, OFS_CTRL, OFS_LOCK, OFS_AUX, OFS_SDRAM, OFS_INIT,
      8'd12, 8'd13, 8'd14, 8'd15,
      OFS_IRQ_ENS, OFS_IRQ_ENC, OFS_SOFT_SET, OFS_SOFT_CLR,
      OFS_FIQ_ENS, OFS_FIQ_ENC: wr_ok = 1'b1;
      default:                  wr_ok = volt_hit;
    endcase
  end

  // ---------------- registered response ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_ok ? rd_val : '0;
      bus_err    <= bus_sel & ~(bus_wr ? wr_ok : rd_ok);
    end
  end

endmodule

// File: rtl/cm_sysctl_chk.sv
module cm_sysctl_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdata_b3,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic              ref_tick,
  input logic              remap_ram,
  input logic              led_on,
  input logic              sys_reset_req,
  input logic [31:0]       osc_q,
  input logic              unlocked,
  input logic [CNT_W-1:0]  ref_cnt
);

  logic [7:0] a8;
  assign a8 = 8'(bus_addr);

  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_sel && !bus_wr));

  a_r4_osc_locked: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_sel && bus_wr && a8 == 8'd2 && !unlocked)) |-> $stable(osc_q));

  a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_sel && bus_wr && a8 == 8'd3)) |-> ($stable(led_on) && $stable(remap_ram)));

  a_r6_reset_cause: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(bus_sel && bus_wr && a8 == 8'd3 && wdata_b3));

  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ref_tick)) |-> (ref_cnt == $past(ref_cnt) + 1'b1));

  a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ref_tick)) |-> $stable(ref_cnt));

  a_r11_volt_no_err: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && a8 >= 8'd32 && a8 <= 8'd35) |-> !bus_err);

  a_r12_err_cause: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel));

endmodule

bind cm_sysctl cm_sysctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .wdata_b3     (bus_wdata[3]),
  .bus_rvalid   (bus_rvalid),
  .bus_err      (bus_err),
  .ref_tick     (ref_tick),
  .remap_ram    (remap_ram),
  .led_on       (led_on),
  .sys_reset_req(sys_reset_req),
  .osc_q        (osc_q),
  .unlocked     (unlocked),
  .ref_cnt      (ref_cnt)
);

// File: tb/sim_cm_sysctl.sv
`timescale 1ns/1ps
module sim_cm_sysctl;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          bus_err;
  logic          ref_tick = 1'b0;
  logic          remap_ram;
  logic          led_on;
  logic          sys_reset_req;

  always #10 clk = ~clk;

  cm_sysctl #(.ADDR_W(AW), .MEM_MB(128)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bus_err(bus_err), .ref_tick(ref_tick), .remap_ram(remap_ram), .led_on(led_on),
    .sys_reset_req(sys_reset_req)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb.size() == 0) begin
        check("R2 unexpected read data", 32'(bus_rvalid), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, bus_rdata, e.data);
        check({e.tag, " err"}, 32'(bus_err), 32'(e.err));
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input logic err,
                    input string tag, input logic tick = 1'b0);
    sb.push_back('{data: exp, err: err, tag: tag});
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a); ref_tick = tick;
    @(negedge clk);
    bus_sel = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic err, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check({tag, " write err"}, 32'(bus_err), 32'(err));
  endtask

  task automatic tick_once();
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5 / R6 reset state of outputs
    check("R5 led after reset", 32'(led_on), 32'd0);
    check("R5 remap after reset", 32'(remap_ram), 32'd0);
    check("R6 reset req idle", 32'(sys_reset_req), 32'd0);
    check("R2 no valid after reset", 32'(bus_rvalid), 32'd0);

    // R1 constants, R8 reset values
    rd(8'd0, 32'h411A3001, 1'b0, "R1 id");
    rd(8'd1, 32'h0, 1'b0, "R1 proc");
    rd(8'd4, 32'h00100000, 1'b0, "R1 status");
    wr(8'd0, 32'h1234, 1'b1, "R1 id");
    rd(8'd0, 32'h411A3001, 1'b0, "R1 id after write");
    rd(8'd2, 32'h01000048, 1'b0, "R8 osc reset");
    rd(8'd7, 32'h0007FEFF, 1'b0, "R8 aux reset");
    rd(8'd9, 32'h00000112, 1'b0, "R8 init reset");
    rd(8'd8, 32'h0001112E, 1'b0, "R8 sdram reset 128MB");

    // R3 lock, R4 gating
    wr(8'd5, 32'hFFFF1234, 1'b0, "R3 lock");
    rd(8'd5, 32'h00001234, 1'b0, "R3 lock low half");
    wr(8'd2, 32'hDEADBEEF, 1'b0, "R4 osc locked");
    wr(8'd7, 32'h0BADF00D, 1'b0, "R4 aux locked");
    rd(8'd2, 32'h01000048, 1'b0, "R4 osc ignored");
    rd(8'd7, 32'h0007FEFF, 1'b0, "R4 aux ignored");
    wr(8'd5, 32'h7777A05F, 1'b0, "R3 key");
    rd(8'd5, 32'h0001A05F, 1'b0, "R3 unlocked read");
    wr(8'd2, 32'h12345678, 1'b0, "R4 osc unlocked");
    wr(8'd7, 32'h00000055, 1'b0, "R4 aux unlocked");
    rd(8'd2, 32'h12345678, 1'b0, "R4 osc written");
    rd(8'd7, 32'h00000055, 1'b0, "R4 aux written");
    wr(8'd5, 32'h0, 1'b0, "R3 relock");
    wr(8'd2, 32'h0, 1'b0, "R4 osc relocked");
    rd(8'd2, 32'h12345678, 1'b0, "R4 osc kept");

    // R5 / R6 control
    wr(8'd3, 32'h00000005, 1'b0, "R5 ctrl");
    check("R5 led on", 32'(led_on), 32'd1);
    check("R5 remap on", 32'(remap_ram), 32'd1);
    check("R6 no pulse without bit3", 32'(sys_reset_req), 32'd0);
    rd(8'd3, 32'h00000005, 1'b0, "R5 ctrl readback");
    wr(8'd3, 32'hFFFFFFFE, 1'b0, "R6 ctrl with reset");
    check("R6 pulse high", 32'(sys_reset_req), 32'd1);
    check("R5 led follows bit0 in reset cycle", 32'(led_on), 32'd0);
    check("R5 remap follows bit2", 32'(remap_ram), 32'd1);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(sys_reset_req), 32'd0);
    rd(8'd3, 32'h00000004, 1'b0, "R6 bit3 reads zero");
    wr(8'd3, 32'h0, 1'b0, "R5 ctrl clear");
    check("R5 remap off", 32'(remap_ram), 32'd0);

    // R7 flags
    wr(8'd12, 32'h0000F0F0, 1'b0, "R7 set");
    wr(8'd12, 32'h0000000F, 1'b0, "R7 set");
    rd(8'd12, 32'h0000F0FF, 1'b0, "R7 flags OR");
    wr(8'd13, 32'h000000F3, 1'b0, "R7 clr");
    rd(8'd12, 32'h0000F00C, 1'b0, "R7 flags cleared");
    wr(8'd14, 32'hAAAA0000, 1'b0, "R7 nv set");
    wr(8'd15, 32'h20000000, 1'b0, "R7 nv clr");
    rd(8'd14, 32'h8AAA0000, 1'b0, "R7 nv flags");
    rd(8'd12, 32'h0000F00C, 1'b0, "R7 volatile untouched");

    // R8 plain words
    wr(8'd8, 32'h00000003, 1'b0, "R8 sdram");
    rd(8'd8, 32'h00000003, 1'b0, "R8 sdram written");
    wr(8'd9, 32'h00000007, 1'b0, "R8 init");
    rd(8'd9, 32'h00000007, 1'b0, "R8 init written");

    // R9 counter, including tick coincident with read
    rd(8'd10, 32'd0, 1'b0, "R9 count zero");
    for (int i = 0; i < 5; i++) tick_once();
    rd(8'd10, 32'd5, 1'b0, "R9 count five");
    rd(8'd10, 32'd5, 1'b0, "R9 read in tick cycle", 1'b1);
    rd(8'd10, 32'd6, 1'b0, "R9 count after tick");
    wr(8'd10, 32'hFFFF0000, 1'b1, "R9 write discarded");
    rd(8'd10, 32'd6, 1'b0, "R9 count unchanged");

    // R10 interrupt registers
    wr(8'd18, 32'h00000101, 1'b0, "R10 irq en set");
    rd(8'd18, 32'h00000101, 1'b0, "R10 irq en");
    rd(8'd16, 32'h0, 1'b0, "R10 irq status idle");
    wr(8'd20, 32'h00000003, 1'b0, "R10 soft set");
    rd(8'd17, 32'h1, 1'b0, "R10 raw level");
    rd(8'd20, 32'h1, 1'b0, "R10 soft read");
    rd(8'd16, 32'h1, 1'b0, "R10 irq status");
    wr(8'd19, 32'h1, 1'b0, "R10 irq en clr");
    rd(8'd16, 32'h0, 1'b0, "R10 irq masked");
    rd(8'd18, 32'h00000100, 1'b0, "R10 irq en after clr");
    wr(8'd26, 32'h1, 1'b0, "R10 fiq en set");
    rd(8'd24, 32'h1, 1'b0, "R10 fiq status");
    rd(8'd25, 32'h1, 1'b0, "R10 fiq raw");
    wr(8'd21, 32'h1, 1'b0, "R10 soft clr");
    rd(8'd24, 32'h0, 1'b0, "R10 fiq status cleared");
    wr(8'd27, 32'h1, 1'b0, "R10 fiq en clr");
    rd(8'd26, 32'h0, 1'b0, "R10 fiq en");

    // R11 voltage block
    wr(8'd33, 32'hFFFFFFFF, 1'b0, "R11 volt write");
    rd(8'd33, 32'h0, 1'b0, "R11 volt read");
    rd(8'd35, 32'h0, 1'b0, "R11 volt top read");

    // R12 unimplemented
    rd(8'd6, 32'h0, 1'b1, "R12 read hole");
    rd(8'd40, 32'h0, 1'b1, "R12 read beyond");
    rd(8'd13, 32'h0, 1'b1, "R12 read write-only");
    wr(8'd11, 32'hFFFFFFFF, 1'b1, "R12 write hole");
    wr(8'd17, 32'hFFFFFFFF, 1'b1, "R12 write read-only");
    rd(8'd17, 32'h0, 1'b0, "R12 raw unchanged");
    @(negedge clk);
    check("R12 err one cycle", 32'(bus_err), 32'd0);

    repeat (3) @(negedge clk);
    check("R2 all reads answered", 32'(sb.size()), 32'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule